// File: doc/BRIEF.md
# Full-Duplex Receive Runt Filter

This block sits between a receive byte FIFO and a receive DMA engine. It tells the DMA engine when it may begin moving a frame, and it decides whether a short frame is kept or thrown away. A small control register holds three bits. From these bits, the selected line port and a link-test-disable input, the block resolves the effective duplex mode.

When runt blocking is enabled and the effective mode is full duplex, the block holds back DMA. It waits until 64 bytes have arrived or the frame has ended, whichever comes first. If the frame ends before reaching 64 bytes, the block discards it. In every other case, frames of any length are kept and DMA start follows the FIFO watermark. A frame that ends before reaching the watermark still gets a start at its end.

The frame tracker is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No frame in progress. |
| `ST_HOLD` | Filtering; waiting for 64 bytes or the end of the frame. |
| `ST_WAIT_WM` | Pass mode; waiting for the watermark. |
| `ST_STREAM` | DMA started; waiting for the end of the frame. |

The state machine has these transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| open | `ST_IDLE` | `ST_HOLD` or `ST_WAIT_WM` | First byte. |
| early start | `ST_IDLE` | `ST_STREAM` | First byte already meets the start condition. |
| launch | `ST_HOLD` or `ST_WAIT_WM` | `ST_STREAM` | Start condition met. |
| close | any non-idle state | `ST_IDLE` | End of frame, with or without a start or a discard. |
| fault | any non-idle state | `ST_IDLE` | Receive error, with a discard. |
| abort | any state | `ST_IDLE` | Soft reset or stop, with no pulse. |

A start condition met on the same byte that ends the frame gives a close with a start, not a launch.

Top module: `fdx_runt_gate`

## Requirements
- R1: `reg_rdata` shows bit 0 = runt blocking, bit 1 = full-duplex enable and bit 2 = port-AUI full duplex. A write sets these bits from the same positions of `reg_wdata`. Bits 15:3 ignore writes and read as zero.
- R2: A low `rst_n` clears all three control bits and both pulse outputs. `soft_rst` and `stop_req` leave the register unchanged. They abandon any frame in progress without emitting a pulse.
- R3: With full-duplex enable clear, `full_duplex` is 0 whatever the other bits, the port code and `link_test_dis` are.
- R4: With port code 1 (AUI), `full_duplex` is 1 only when full-duplex enable and AUI full duplex are both set.
- R5: With full-duplex enable set, each port code resolves as follows:
  - Code 0 (twisted pair) is full duplex unless `link_test_dis` is high.
  - Code 2 (MII) is full duplex.
  - Code 3 is always half duplex.
- R6: Filtering for a frame is fixed on its first byte: it is on when runt blocking is set and `full_duplex` is 1. A register write during a frame takes effect from the next frame.
- R7: With filtering on, `dma_start` pulses in the cycle after the 64th byte is sampled. A frame longer than 64 bytes gets no further start.
- R8: With filtering on, a frame that ends with fewer than 64 bytes yields a one-cycle `frame_drop` in the cycle after `rx_eof` is sampled, and no `dma_start`.
- R9: With filtering off, `dma_start` pulses in the cycle after the first frame byte sampled with `fifo_level >= fifo_wmark`. If the frame ends first, the pulse comes in the cycle after `rx_eof` instead. No frame is dropped for its length.
- R10: `dma_start` is issued at most once per frame and never in the same cycle as `frame_drop`.
- R11: `rx_err` during a frame ends it. It yields a one-cycle `frame_drop` in the next cycle and no later `dma_start` for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset: aborts frame tracking, keeps the register |
| stop_req | input | 1 | Stop command: aborts frame tracking, keeps the register |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Control register write data |
| reg_rdata | output | REG_W | Control register read data |
| port_sel | input | 2 | Active port: 0 twisted pair, 1 AUI, 2 MII, 3 none |
| link_test_dis | input | 1 | Link test disabled; forces twisted pair to half duplex |
| rx_byte_vld | input | 1 | One received byte this cycle; the first byte when idle opens a frame |
| rx_eof | input | 1 | Frame ends this cycle (with or after its last byte) |
| rx_err | input | 1 | Receive error in the current frame |
| fifo_level | input | LVL_W | Bytes currently held in the receive FIFO |
| fifo_wmark | input | LVL_W | Programmed FIFO watermark |
| full_duplex | output | 1 | Effective duplex mode resolved from the register and port |
| dma_start | output | 1 | One-cycle request to start receive DMA |
| frame_drop | output | 1 | One-cycle strobe: discard the current frame |

## Verification
A register write can land in the same cycle as a frame byte. That write changes `full_duplex` at once, but the open frame must keep its filtering setting. The bench writes the register to zero on byte 10 of a 100-byte filtered frame while the watermark sits at 8. It expects the start at byte 64 rather than byte 8. The following short frame is then expected to start at the watermark with no discard.

// File: rtl/fdx_pkg.sv
package fdx_pkg;

    typedef enum logic [1:0] {
        PORT_TP   = 2'd0,
        PORT_AUI  = 2'd1,
        PORT_MII  = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_WAIT_WM = 2'd2,
        ST_STREAM  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic aui_fd;
        logic fd_en;
        logic runt_block;
    } dx_ctrl_t;

    localparam int unsigned CTRL_BITS = 3;

endpackage

// File: rtl/fdx_ctrl_reg.sv
module fdx_ctrl_reg
    import fdx_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output dx_ctrl_t         ctrl,
    output logic [REG_W-1:0] rdata
);

    dx_ctrl_t ctrl_q;

    // Hard reset only; soft reset and stop are not connected here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.runt_block <= wdata[0];
            ctrl_q.fd_en      <= wdata[1];
            ctrl_q.aui_fd     <= wdata[2];
        end
    end

    always_comb begin
        rdata    = '0;
        rdata[0] = ctrl_q.runt_block;
        rdata[1] = ctrl_q.fd_en;
        rdata[2] = ctrl_q.aui_fd;
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/fdx_mode_resolve.sv
module fdx_mode_resolve
    import fdx_pkg::*;
(
    input  dx_ctrl_t   ctrl,
    input  logic [1:0] port_sel,
    input  logic       link_test_dis,
    output logic       full_dx,
    output logic       filt_now
);

    port_e port_v;

    always_comb begin
        port_v = port_e'(port_sel);
        full_dx = 1'b0;
        if (ctrl.fd_en) begin
            unique case (port_v)
                PORT_TP:   full_dx = !link_test_dis;
                PORT_AUI:  full_dx = ctrl.aui_fd;
                PORT_MII:  full_dx = 1'b1;
                PORT_NONE: full_dx = 1'b0;
                default:   full_dx = 1'b0;
            endcase
        end
        filt_now = full_dx && ctrl.runt_block;
    end

endmodule

// File: rtl/fdx_len_counter.sv
module fdx_len_counter #(
    parameter int unsigned MIN_LEN = 64,
    localparam int unsigned CNT_W = $clog2(MIN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic abort,
    input  logic inc,
    output logic long_enough
);

    localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        base = restart ? '0 : cnt_q;
        nxt  = (inc && (base < LIM)) ? base + 1'b1 : base;
        long_enough = (nxt >= LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt;
        end
    end

endmodule

// File: rtl/fdx_frame_fsm.sv
module fdx_frame_fsm
    import fdx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic byte_vld,
    input  logic eof,
    input  logic err,
    input  logic filt_now,
    input  logic long_enough,
    input  logic wm_hit,
    output logic restart,
    output logic dma_start,
    output logic frame_drop
);

    rx_state_e state_q;
    rx_state_e state_d;
    logic      filt_q;
    logic      filt;
    logic      fire_start;
    logic      fire_drop;
    logic      go_cond;

    assign restart = (state_q == ST_IDLE) && byte_vld && !abort;
    assign filt    = restart ? filt_now : filt_q;
    assign go_cond = filt ? long_enough : wm_hit;

    // Next state and pulse decisions
    always_comb begin
        state_d    = state_q;
        fire_start = 1'b0;
        fire_drop  = 1'b0;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD, ST_WAIT_WM: begin
                    if (state_q != ST_IDLE || byte_vld) begin
                        if (err) begin
                            fire_drop = 1'b1;
                            state_d   = ST_IDLE;
                        end else if (eof) begin
                            state_d = ST_IDLE;
                            if (filt && !long_enough) begin
                                fire_drop = 1'b1;
                            end else begin
                                fire_start = 1'b1;
                            end
                        end else if (go_cond) begin
                            fire_start = 1'b1;
                            state_d    = ST_STREAM;
                        end else begin
                            state_d = filt ? ST_HOLD : ST_WAIT_WM;
                        end
                    end
                end
                ST_STREAM: begin
                    if (err) begin
                        fire_drop = 1'b1;
                        state_d   = ST_IDLE;
                    end else if (eof) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (restart) begin
                filt_q <= filt_now;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_start  <= 1'b0;
            frame_drop <= 1'b0;
        end else begin
            dma_start  <= fire_start;
            frame_drop <= fire_drop;
        end
    end

endmodule

// File: rtl/fdx_runt_gate.sv
module fdx_runt_gate
    import fdx_pkg::*;
#(
    parameter int unsigned REG_W   = 16,
    parameter int unsigned LVL_W   = 8,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop_req,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [1:0]       port_sel,
    input  logic             link_test_dis,
    input  logic             rx_byte_vld,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_wmark,
    output logic             full_duplex,
    output logic             dma_start,
    output logic             frame_drop
);

    dx_ctrl_t ctrl;
    logic     filt_now;
    logic     long_enough;
    logic     restart;
    logic     abort;
    logic     wm_hit;

    assign abort  = soft_rst || stop_req;
    assign wm_hit = (fifo_level >= fifo_wmark);

    fdx_ctrl_reg #(.REG_W(REG_W)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    fdx_mode_resolve mode_i (
        .ctrl          (ctrl),
        .port_sel      (port_sel),
        .link_test_dis (link_test_dis),
        .full_dx       (full_duplex),
        .filt_now      (filt_now)
    );

    fdx_len_counter #(.MIN_LEN(MIN_LEN)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .abort       (abort),
        .inc         (rx_byte_vld),
        .long_enough (long_enough)
    );

    fdx_frame_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (abort),
        .byte_vld    (rx_byte_vld),
        .eof         (rx_eof),
        .err         (rx_err),
        .filt_now    (filt_now),
        .long_enough (long_enough),
        .wm_hit      (wm_hit),
        .restart     (restart),
        .dma_start   (dma_start),
        .frame_drop  (frame_drop)
    );

endmodule

// File: rtl/fdx_runt_gate_chk.sv
module fdx_runt_gate_chk #(
    parameter int unsigned REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             stop_req,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_rdata,
    input logic [1:0]       port_sel,
    input logic             link_test_dis,
    input logic             full_duplex,
    input logic             dma_start,
    input logic             frame_drop
);

    AST_HALF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[1] |-> !full_duplex); // R3

    AST_AUI_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel == 2'd1) |-> (full_duplex == (reg_rdata[1] && reg_rdata[2]))); // R4

    AST_MII_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel == 2'd2 && reg_rdata[1]) |-> full_duplex); // R5

    AST_TP_LINKTEST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel == 2'd0 && link_test_dis) |-> !full_duplex); // R5

    AST_HARD_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && !dma_start && !frame_drop)); // R2

    AST_SOFT_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_rst || stop_req) && !reg_wr_en) |=> $stable(reg_rdata)); // R2

    AST_ABORT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || stop_req) |=> (!dma_start && !frame_drop)); // R2

    AST_START_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && frame_drop)); // R10

endmodule

bind fdx_runt_gate fdx_runt_gate_chk #(.REG_W(REG_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .stop_req      (stop_req),
    .reg_wr_en     (reg_wr_en),
    .reg_rdata     (reg_rdata),
    .port_sel      (port_sel),
    .link_test_dis (link_test_dis),
    .full_duplex   (full_duplex),
    .dma_start     (dma_start),
    .frame_drop    (frame_drop)
);

// File: tb/fdx_runt_gate_tb_top.sv
module fdx_runt_gate_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned REG_W = 16;
    localparam int unsigned LVL_W = 8;
    localparam int unsigned NVEC  = 10;

    // {ctrl[2:0] (aui,fden,runt), port[1:0], link_test_dis, expected full_duplex}
    localparam logic [6:0] VEC [NVEC] = '{
        {3'b000, 2'd0, 1'b0, 1'b0},  // R3
        {3'b101, 2'd2, 1'b0, 1'b0},  // R3
        {3'b100, 2'd1, 1'b0, 1'b0},  // R3
        {3'b110, 2'd1, 1'b0, 1'b1},  // R4
        {3'b010, 2'd1, 1'b0, 1'b0},  // R4
        {3'b010, 2'd0, 1'b0, 1'b1},  // R5
        {3'b010, 2'd0, 1'b1, 1'b0},  // R5
        {3'b010, 2'd2, 1'b1, 1'b1},  // R5
        {3'b011, 2'd2, 1'b0, 1'b1},  // R5
        {3'b110, 2'd3, 1'b0, 1'b0}   // R5
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             stop_req = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic [1:0]       port_sel = 2'd2;
    logic             link_test_dis = 1'b0;
    logic             rx_byte_vld = 1'b0;
    logic             rx_eof = 1'b0;
    logic             rx_err = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic [LVL_W-1:0] fifo_wmark = 8'd16;
    logic             full_duplex;
    logic             dma_start;
    logic             frame_drop;

    int n_checks = 0;
    int n_bad = 0;
    int seen_bytes = 0;
    int n_starts = 0;
    int n_drops = 0;
    int last_start_at = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fdx_runt_gate #(.REG_W(REG_W), .LVL_W(LVL_W), .MIN_LEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_req(stop_req),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_sel(port_sel), .link_test_dis(link_test_dis),
        .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof), .rx_err(rx_err),
        .fifo_level(fifo_level), .fifo_wmark(fifo_wmark),
        .full_duplex(full_duplex), .dma_start(dma_start), .frame_drop(frame_drop)
    );

    always @(posedge clk) begin
        if (rx_byte_vld) seen_bytes <= seen_bytes + 1;
    end

    always @(negedge clk) begin
        if (dma_start) begin
            n_starts <= n_starts + 1;
            last_start_at <= seen_bytes;
        end
        if (frame_drop) n_drops <= n_drops + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [REG_W-1:0] v);
        @(posedge clk); #1;
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    // Send a frame; err_at / wr_at are 1-based byte indices, 0 = none.
    task automatic frame(input int len, input int err_at, input int wr_at,
                         input logic [REG_W-1:0] wr_v, input int exp_starts,
                         input int exp_drops, input int exp_at, input string req);
        int base_bytes, base_starts, base_drops;
        @(posedge clk); #1;
        base_bytes  = seen_bytes;
        base_starts = n_starts;
        base_drops  = n_drops;
        for (int i = 1; i <= len; i++) begin
            if (i > 1) begin
                @(posedge clk); #1;
            end
            rx_byte_vld = 1'b1;
            fifo_level  = LVL_W'(i > 255 ? 255 : i);
            rx_eof      = (i == len) && (err_at == 0);
            rx_err      = (i == err_at);
            reg_wr_en   = (i == wr_at);
            reg_wdata   = wr_v;
            if (i == err_at) break;
        end
        @(posedge clk); #1;
        rx_byte_vld = 1'b0;
        rx_eof = 1'b0;
        rx_err = 1'b0;
        reg_wr_en = 1'b0;
        fifo_level = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(n_starts - base_starts == exp_starts, {req, " start count"},
              n_starts - base_starts, exp_starts);
        check(n_drops - base_drops == exp_drops, {req, " drop count"},
              n_drops - base_drops, exp_drops);
        if (exp_starts == 1)
            check(last_start_at - base_bytes == exp_at, {req, " start byte"},
                  last_start_at - base_bytes, exp_at);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        check(reg_rdata == 0, "R2 reset reg", int'(reg_rdata), 0);
        check(!dma_start && !frame_drop, "R2 reset pulses", int'({dma_start, frame_drop}), 0);
        rst_n = 1'b1;

        // R1 reserved bits
        write_reg(16'hFFFF);
        @(negedge clk);
        check(reg_rdata == 16'h0007, "R1 reserved bits", int'(reg_rdata), 7);

        // R3 R4 R5 duplex table
        for (int k = 0; k < NVEC; k++) begin
            write_reg({13'd0, VEC[k][6:4]});
            port_sel = VEC[k][3:2];
            link_test_dis = VEC[k][1];
            @(negedge clk);
            check(full_duplex == VEC[k][0], "R3/R4/R5 duplex vector", int'(full_duplex), int'(VEC[k][0]));
        end

        // R2 soft reset and stop keep register
        write_reg(16'h0005);
        @(posedge clk); #1;
        soft_rst = 1'b1;
        stop_req = 1'b1;
        @(posedge clk); #1;
        soft_rst = 1'b0;
        stop_req = 1'b0;
        @(negedge clk);
        check(reg_rdata == 16'h0005, "R2 soft keep", int'(reg_rdata), 5);

        // R2 hard reset clears
        rst_n = 1'b0;
        @(negedge clk);
        check(reg_rdata == 0, "R2 hard clear", int'(reg_rdata), 0);
        rst_n = 1'b1;

        // Filtering on: MII, runt block + fd enable
        port_sel = 2'd2;
        link_test_dis = 1'b0;
        fifo_wmark = 8'd8;
        write_reg(16'h0003);
        frame(40, 0, 0, 0, 0, 1, 0, "R8 short dropped");
        frame(100, 0, 0, 0, 1, 0, 64, "R7 long start at 64");
        frame(64, 0, 0, 0, 1, 0, 64, "R7 exact 64");
        frame(1, 0, 0, 0, 0, 1, 0, "R8 one byte");
        frame(30, 30, 0, 0, 0, 1, 0, "R11 error before start");
        frame(100, 70, 0, 0, 1, 1, 64, "R11 error after start");

        // R6 write mid-frame affects the next frame only
        frame(100, 0, 10, 16'h0000, 1, 0, 64, "R6 mid-frame write");
        frame(20, 0, 0, 0, 1, 0, 8, "R6 next frame pass");

        // Pass mode: AUI without aui full duplex
        write_reg(16'h0003);
        port_sel = 2'd1;
        fifo_wmark = 8'd16;
        frame(40, 0, 0, 0, 1, 0, 16, "R9 watermark start");
        frame(10, 0, 0, 0, 1, 0, 10, "R9 end before watermark");
        fifo_wmark = 8'd1;
        frame(100, 0, 0, 0, 1, 0, 1, "R10 single start");

        // R3 fd enable clear: no filtering
        port_sel = 2'd2;
        fifo_wmark = 8'd8;
        write_reg(16'h0001);
        frame(20, 0, 0, 0, 1, 0, 8, "R3 half duplex pass");

        // R5 twisted pair with link test disabled: no filtering
        write_reg(16'h0003);
        port_sel = 2'd0;
        link_test_dis = 1'b1;
        frame(12, 0, 0, 0, 1, 0, 8, "R5 link test half");

        // R2 stop mid-frame abandons frame
        link_test_dis = 1'b0;
        fifo_wmark = 8'd200;
        begin
            int bs, bd;
            bs = n_starts;
            bd = n_drops;
            @(posedge clk); #1;
            rx_byte_vld = 1'b1;
            fifo_level = 8'd1;
            repeat (5) begin
                @(posedge clk); #1;
            end
            rx_byte_vld = 1'b0;
            stop_req = 1'b1;
            @(posedge clk); #1;
            stop_req = 1'b0;
            rx_eof = 1'b1;
            @(posedge clk); #1;
            rx_eof = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(n_starts == bs && n_drops == bd, "R2 stop abandons frame",
                  (n_starts - bs) + (n_drops - bd), 0);
            check(reg_rdata == 16'h0003, "R2 stop keeps reg", int'(reg_rdata), 3);
        end
        fifo_wmark = 8'd8;
        frame(30, 0, 0, 0, 0, 1, 0, "R8 after stop");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule